// File: doc/BRIEF.md
# Codec System Clock Controller

This block builds the system clock of an audio codec and the clocks hanging off it. It works in a single fast reference domain, and every clock appears as a one-cycle enable pulse in that domain. The root source is either the master clock pulse stream or the frequency-locked-loop pulse stream. An optional halving stage and an enable gate follow the source choice. The system clock feeds three derived pulses, each with its own enable, and each needs every enable above it in the tree:

- a DSP clock enable;
- a tick at about 256 kHz, with a programmable divisor;
- a slow timeout tick taken from the 256 kHz tick, with its own programmable divisor (typically 256).

A separate checker looks at the converter configuration. It compares the nominal system clock frequency against the sample rate, both given as integers in Hz, and raises a flag for each clocking rule that the current settings break.

Top module: `sysclk_ctrl`

## Requirements
- R1: `src_sel` reads 0 out of reset. With `src_sel` = 0 the root is `mclk_pulse`; with `src_sel` = 1 it is `fll_pulse`. `src_sel` takes `src_wr_val` one cycle after a write strobe `src_wr` that is accepted.
- R2: While `sysclk_en` = 1, `sysclk_pulse` is high in the cycle after a root pulse. With `half_en` = 0 this happens for every root pulse. With `half_en` = 1 it happens only for the 2nd, 4th, 6th... root pulse counted since `sysclk_en` last went to 1.
- R3: A `src_wr` strobe while `sysclk_en` = 1 leaves `src_sel` unchanged. The strobe also sets `src_viol` to 1 in the next cycle, and `src_viol` stays at 1 until reset.
- R4: While `sysclk_en` = 0, `sysclk_pulse` is 0 from the next cycle on. The halving phase restarts as well.
- R5: `dsp_pulse` is high exactly when `sysclk_pulse` is high and `dsp_en` was 1 at the same edge.
- R6: While both `tick_en` and `sysclk_en` are 1, `tick_pulse` goes high in the cycle after every `tick_div`-th system clock pulse. A divisor of 0 or 1 counts as 1. Clearing either enable clears the count, so after re-enable the first tick needs a full `tick_div` system pulses.
- R7: While `tmo_en`, `tick_en` and `sysclk_en` are all 1, `tmo_pulse` goes high in the cycle after every `tmo_div`-th `tick_pulse`. Clearing any of those enables clears its count.
- R8: `err_dac_ratio` is 1 when either DAC channel is on and `sysclk_hz` is below the required multiple of `fs_hz`. The multiple is 128 for stereo at low OSR, 256 for stereo at high OSR, 64 for mono at low OSR and 128 for mono at high OSR.
- R9: `err_adc_ratio` is 1 when either ADC channel is on and `sysclk_hz` is below `fs_hz` times 128 at low ADC OSR, or times 256 at high ADC OSR.
- R10: `err_abs_min` is 1 when `sysclk_hz` is below 3,000,000 with `dac_hi_osr` = 0, or below 6,000,000 with `dac_hi_osr` = 1.
- R11: `err_hirate` is 1 when at least one ADC channel and at least one DAC channel are on and `fs_hz` is 88,200 or more. All four checker flags are registered and follow their inputs one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mclk_pulse | input | 1 | Master clock as an enable pulse |
| fll_pulse | input | 1 | Frequency-locked-loop output as an enable pulse |
| src_wr | input | 1 | Write strobe for the root source select |
| src_wr_val | input | 1 | Value written to the source select |
| sysclk_en | input | 1 | System clock enable |
| half_en | input | 1 | Halve the selected source |
| dsp_en | input | 1 | DSP clock enable |
| tick_en | input | 1 | 256 kHz tick enable |
| tmo_en | input | 1 | Timeout tick enable |
| tick_div | input | DIV_W | System pulses per 256 kHz tick |
| tmo_div | input | TMO_W | 256 kHz ticks per timeout tick |
| dac_l_on | input | 1 | Left DAC active |
| dac_r_on | input | 1 | Right DAC active |
| adc_l_on | input | 1 | Left ADC active |
| adc_r_on | input | 1 | Right ADC active |
| dac_mono | input | 1 | DAC mono mode |
| dac_hi_osr | input | 1 | DAC high oversampling |
| adc_hi_osr | input | 1 | ADC high oversampling |
| sysclk_hz | input | HZ_W | Nominal system clock frequency in Hz |
| fs_hz | input | HZ_W | Sample rate in Hz |
| src_sel | output | 1 | Current root source select |
| src_viol | output | 1 | Sticky flag for a blocked source change |
| sysclk_pulse | output | 1 | System clock enable pulse |
| dsp_pulse | output | 1 | DSP clock enable pulse |
| tick_pulse | output | 1 | 256 kHz tick |
| tmo_pulse | output | 1 | Timeout tick |
| err_dac_ratio | output | 1 | DAC clock ratio too low |
| err_adc_ratio | output | 1 | ADC clock ratio too low |
| err_abs_min | output | 1 | System clock below the absolute floor |
| err_hirate | output | 1 | ADC and DAC both active at a high sample rate |

## Verification
The assertions assume that `mclk_pulse` and `fll_pulse` are single-cycle strobes sampled at the reference edge. They also assume that the enables and the divisor inputs change only between edges. The stimulus drives every input on the falling edge, so each value is stable before the next rising edge. Enables are toggled rarely and source pulses arrive at random densities, so long stretches of normal counting occur as well as blocked source writes. The frequency inputs are drawn around the exact ratio thresholds, so each rule is tested just below and just at its limit.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;

    typedef struct packed {
        logic sel;
        logic viol;
        logic phase;
        logic sys;
        logic dsp;
    } root_st_t;

    typedef struct packed {
        logic dac_ratio;
        logic adc_ratio;
        logic abs_min;
        logic hirate;
    } rate_flags_t;

    localparam int unsigned ABS_MIN_LO_HZ = 3_000_000;
    localparam int unsigned ABS_MIN_HI_HZ = 6_000_000;
    localparam int unsigned HIRATE_HZ     = 88_200;

endpackage

// File: rtl/sysclk_root.sv
module sysclk_root
    import sysclk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mclk_pulse,
    input  logic fll_pulse,
    input  logic src_wr,
    input  logic src_wr_val,
    input  logic sysclk_en,
    input  logic half_en,
    input  logic dsp_en,
    output logic src_sel,
    output logic src_viol,
    output logic sys_pulse,
    output logic dsp_pulse
);

    root_st_t st_d, st_q;
    logic     root_hit;

    always_comb begin
        st_d     = st_q;
        root_hit = st_q.sel ? fll_pulse : mclk_pulse;
        if (src_wr) begin
            if (sysclk_en) st_d.viol = 1'b1;
            else           st_d.sel  = src_wr_val;
        end
        if (!sysclk_en) begin
            st_d.phase = 1'b0;
            st_d.sys   = 1'b0;
        end else if (root_hit) begin
            st_d.sys   = half_en ? st_q.phase : 1'b1;
            st_d.phase = half_en ? ~st_q.phase : st_q.phase;
        end else begin
            st_d.sys   = 1'b0;
        end
        st_d.dsp = st_d.sys & dsp_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign src_sel   = st_q.sel;
    assign src_viol  = st_q.viol;
    assign sys_pulse = st_q.sys;
    assign dsp_pulse = st_q.dsp;

    assert_src_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (src_wr && sysclk_en) |=> (src_sel == $past(src_sel)) && src_viol);

    assert_viol_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        src_viol |=> src_viol);

    assert_sys_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sys_pulse |-> $past(sysclk_en));

    assert_dsp_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dsp_pulse |-> $past(dsp_en && sysclk_en));

endmodule

// File: rtl/pulse_divider.sv
module pulse_divider #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         in_pulse,
    input  logic [W-1:0] div,
    output logic         out_pulse
);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         out;
    } div_st_t;

    div_st_t    st_d, st_q;
    logic [W:0] next_cnt;

    always_comb begin
        st_d     = st_q;
        next_cnt = {1'b0, st_q.cnt} + 1'b1;
        st_d.out = 1'b0;
        if (!en) begin
            st_d.cnt = '0;
        end else if (in_pulse) begin
            if (next_cnt >= {1'b0, div}) begin
                st_d.cnt = '0;
                st_d.out = 1'b1;
            end else begin
                st_d.cnt = next_cnt[W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_pulse = st_q.out;

    assert_tick_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_pulse |-> $past(en && in_pulse));

    assert_clear_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (st_q.cnt == '0) && !out_pulse);

endmodule

// File: rtl/rate_checker.sv
module rate_checker
    import sysclk_pkg::*;
#(
    parameter int HZ_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dac_on,
    input  logic            adc_on,
    input  logic            dac_mono,
    input  logic            dac_hi_osr,
    input  logic            adc_hi_osr,
    input  logic [HZ_W-1:0] sysclk_hz,
    input  logic [HZ_W-1:0] fs_hz,
    output rate_flags_t     flags
);

    localparam int PW = HZ_W + 9;

    rate_flags_t   fl_d, fl_q;
    logic [8:0]    dac_mult, adc_mult;
    logic [PW-1:0] sys_ext, dac_need, adc_need;

    always_comb begin
        case ({dac_mono, dac_hi_osr})
            2'b00:   dac_mult = 9'd128;
            2'b01:   dac_mult = 9'd256;
            2'b10:   dac_mult = 9'd64;
            default: dac_mult = 9'd128;
        endcase
        adc_mult  = adc_hi_osr ? 9'd256 : 9'd128;
        sys_ext   = PW'(sysclk_hz);
        dac_need  = PW'(fs_hz) * PW'(dac_mult);
        adc_need  = PW'(fs_hz) * PW'(adc_mult);
        fl_d.dac_ratio = dac_on && (sys_ext < dac_need);
        fl_d.adc_ratio = adc_on && (sys_ext < adc_need);
        fl_d.abs_min   = dac_hi_osr ? (sysclk_hz < HZ_W'(ABS_MIN_HI_HZ))
                                    : (sysclk_hz < HZ_W'(ABS_MIN_LO_HZ));
        fl_d.hirate    = dac_on && adc_on && (fs_hz >= HZ_W'(HIRATE_HZ));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign flags = fl_q;

    assert_dac_needs_path_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flags.dac_ratio |-> $past(dac_on));

    assert_adc_needs_path_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flags.adc_ratio |-> $past(adc_on));

    assert_hirate_both_R11: assert property (@(posedge clk) disable iff (!rst_n)
        flags.hirate |-> $past(dac_on && adc_on));

endmodule

// File: rtl/sysclk_ctrl.sv
module sysclk_ctrl
    import sysclk_pkg::*;
#(
    parameter int DIV_W = 12,
    parameter int TMO_W = 10,
    parameter int HZ_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mclk_pulse,
    input  logic             fll_pulse,
    input  logic             src_wr,
    input  logic             src_wr_val,
    input  logic             sysclk_en,
    input  logic             half_en,
    input  logic             dsp_en,
    input  logic             tick_en,
    input  logic             tmo_en,
    input  logic [DIV_W-1:0] tick_div,
    input  logic [TMO_W-1:0] tmo_div,
    input  logic             dac_l_on,
    input  logic             dac_r_on,
    input  logic             adc_l_on,
    input  logic             adc_r_on,
    input  logic             dac_mono,
    input  logic             dac_hi_osr,
    input  logic             adc_hi_osr,
    input  logic [HZ_W-1:0]  sysclk_hz,
    input  logic [HZ_W-1:0]  fs_hz,
    output logic             src_sel,
    output logic             src_viol,
    output logic             sysclk_pulse,
    output logic             dsp_pulse,
    output logic             tick_pulse,
    output logic             tmo_pulse,
    output logic             err_dac_ratio,
    output logic             err_adc_ratio,
    output logic             err_abs_min,
    output logic             err_hirate
);

    logic        tick_chain_en, tmo_chain_en;
    rate_flags_t flags;

    assign tick_chain_en = tick_en & sysclk_en;
    assign tmo_chain_en  = tmo_en & tick_chain_en;

    sysclk_root u_root (
        .clk        (clk),
        .rst_n      (rst_n),
        .mclk_pulse (mclk_pulse),
        .fll_pulse  (fll_pulse),
        .src_wr     (src_wr),
        .src_wr_val (src_wr_val),
        .sysclk_en  (sysclk_en),
        .half_en    (half_en),
        .dsp_en     (dsp_en),
        .src_sel    (src_sel),
        .src_viol   (src_viol),
        .sys_pulse  (sysclk_pulse),
        .dsp_pulse  (dsp_pulse)
    );

    pulse_divider #(.W(DIV_W)) u_tick_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (tick_chain_en),
        .in_pulse  (sysclk_pulse),
        .div       (tick_div),
        .out_pulse (tick_pulse)
    );

    pulse_divider #(.W(TMO_W)) u_tmo_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (tmo_chain_en),
        .in_pulse  (tick_pulse),
        .div       (tmo_div),
        .out_pulse (tmo_pulse)
    );

    rate_checker #(.HZ_W(HZ_W)) u_rate (
        .clk        (clk),
        .rst_n      (rst_n),
        .dac_on     (dac_l_on | dac_r_on),
        .adc_on     (adc_l_on | adc_r_on),
        .dac_mono   (dac_mono),
        .dac_hi_osr (dac_hi_osr),
        .adc_hi_osr (adc_hi_osr),
        .sysclk_hz  (sysclk_hz),
        .fs_hz      (fs_hz),
        .flags      (flags)
    );

    assign err_dac_ratio = flags.dac_ratio;
    assign err_adc_ratio = flags.adc_ratio;
    assign err_abs_min   = flags.abs_min;
    assign err_hirate    = flags.hirate;

    assert_tmo_chain_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_pulse |-> $past(tick_pulse && tmo_chain_en));

endmodule

// File: tb/test_sysclk_ctrl.sv
module test_sysclk_ctrl;

    localparam int DIV_W = 12;
    localparam int TMO_W = 10;
    localparam int HZ_W  = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mclk_pulse = 0, fll_pulse = 0, src_wr = 0, src_wr_val = 0;
    logic sysclk_en = 0, half_en = 0, dsp_en = 0, tick_en = 0, tmo_en = 0;
    logic [DIV_W-1:0] tick_div = 4;
    logic [TMO_W-1:0] tmo_div = 256;
    logic dac_l_on = 0, dac_r_on = 0, adc_l_on = 0, adc_r_on = 0;
    logic dac_mono = 0, dac_hi_osr = 0, adc_hi_osr = 0;
    logic [HZ_W-1:0] sysclk_hz = 12_288_000, fs_hz = 48_000;
    logic src_sel, src_viol, sysclk_pulse, dsp_pulse, tick_pulse, tmo_pulse;
    logic err_dac_ratio, err_adc_ratio, err_abs_min, err_hirate;

    int n_chk = 0, n_bad = 0;
    int n_tick = 0, n_tmo = 0;

    // reference state
    logic m_sel, m_viol, m_ph, m_sys, m_dsp, m_t1, m_t2;
    int   m_c1, m_c2;
    logic [3:0] m_flags;

    sysclk_ctrl #(.DIV_W(DIV_W), .TMO_W(TMO_W), .HZ_W(HZ_W)) i_sysclk_ctrl (.*);

    always #10 clk = ~clk;

    initial begin
        #4_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    function automatic logic [3:0] ref_flags(
        logic dac, logic adc, logic mono, logic dosr, logic aosr,
        longint sys, longint fs);
        longint dm, am;
        logic [3:0] f;
        dm = mono ? (dosr ? 128 : 64) : (dosr ? 256 : 128);
        am = aosr ? 256 : 128;
        f[3] = dac && (sys < fs * dm);
        f[2] = adc && (sys < fs * am);
        f[1] = sys < (dosr ? 64'd6_000_000 : 64'd3_000_000);
        f[0] = dac && adc && (fs >= 88_200);
        return f;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // advance one reference cycle, update model at the edge, compare at negedge
    task automatic step();
        logic root, o_sys, o_t1;
        int   d1, d2;
        @(posedge clk);
        o_sys = m_sys; o_t1 = m_t1;
        root = m_sel ? fll_pulse : mclk_pulse;
        if (src_wr) begin
            if (sysclk_en) m_viol = 1'b1;
            else           m_sel  = src_wr_val;
        end
        if (!sysclk_en) begin
            m_ph = 0; m_sys = 0;
        end else if (root) begin
            m_sys = half_en ? m_ph : 1'b1;
            if (half_en) m_ph = ~m_ph;
        end else m_sys = 0;
        m_dsp = m_sys & dsp_en;
        d1 = (tick_div < 2) ? 1 : int'(tick_div);
        d2 = (tmo_div < 2) ? 1 : int'(tmo_div);
        m_t2 = 0;
        if (!(tmo_en && tick_en && sysclk_en)) m_c2 = 0;
        else if (o_t1) begin
            if (m_c2 + 1 >= d2) begin m_c2 = 0; m_t2 = 1; end
            else m_c2++;
        end
        m_t1 = 0;
        if (!(tick_en && sysclk_en)) m_c1 = 0;
        else if (o_sys) begin
            if (m_c1 + 1 >= d1) begin m_c1 = 0; m_t1 = 1; end
            else m_c1++;
        end
        m_flags = ref_flags(dac_l_on | dac_r_on, adc_l_on | adc_r_on, dac_mono,
                            dac_hi_osr, adc_hi_osr, longint'(sysclk_hz), longint'(fs_hz));
        @(negedge clk);
        if (tick_pulse) n_tick++;
        if (tmo_pulse)  n_tmo++;
        check("R1 src_sel", src_sel, m_sel);
        check("R3 src_viol", src_viol, m_viol);
        check("R2/R4 sysclk_pulse", sysclk_pulse, m_sys);
        check("R5 dsp_pulse", dsp_pulse, m_dsp);
        check("R6 tick_pulse", tick_pulse, m_t1);
        check("R7 tmo_pulse", tmo_pulse, m_t2);
        check("R8 err_dac_ratio", err_dac_ratio, m_flags[3]);
        check("R9 err_adc_ratio", err_adc_ratio, m_flags[2]);
        check("R10 err_abs_min", err_abs_min, m_flags[1]);
        check("R11 err_hirate", err_hirate, m_flags[0]);
    endtask

    task automatic set_rate(logic dl, logic al, logic mono, logic dosr, logic aosr,
                            int unsigned sys, int unsigned fs);
        dac_l_on = dl; dac_r_on = 0; adc_l_on = 0; adc_r_on = al;
        dac_mono = mono; dac_hi_osr = dosr; adc_hi_osr = aosr;
        sysclk_hz = sys; fs_hz = fs;
        step();
    endtask

    initial begin
        int unsigned seed;
        seed = 32'h5eed_c10c;
        void'($urandom(seed));
        m_sel = 0; m_viol = 0; m_ph = 0; m_sys = 0; m_dsp = 0; m_t1 = 0; m_t2 = 0;
        m_c1 = 0; m_c2 = 0; m_flags = 0;
        repeat (3) @(negedge clk);
        // reset state, R1
        check("R1 reset src_sel", src_sel, 0);
        check("R3 reset src_viol", src_viol, 0);
        check("R4 reset sysclk_pulse", sysclk_pulse, 0);
        rst_n = 1;
        m_flags = ref_flags(0, 0, 0, 0, 0, 12_288_000, 48_000);

        // R1: select FLL while off, then only FLL pulses reach the output
        src_wr = 1; src_wr_val = 1; step(); src_wr = 0;
        check("R1 select fll", src_sel, 1);
        sysclk_en = 1; dsp_en = 1;
        mclk_pulse = 1; fll_pulse = 0; step();
        check("R1 mclk ignored when fll selected", sysclk_pulse, 0);
        mclk_pulse = 0; fll_pulse = 1; step();
        check("R1 fll pulse passes", sysclk_pulse, 1);
        fll_pulse = 0;

        // R3: blocked source change
        src_wr = 1; src_wr_val = 0; step(); src_wr = 0;
        check("R3 write blocked", src_sel, 1);
        check("R3 viol raised", src_viol, 1);
        sysclk_en = 0; step(); step();
        check("R3 viol sticky", src_viol, 1);
        src_wr = 1; src_wr_val = 0; step(); src_wr = 0;
        check("R1 write accepted when off", src_sel, 0);

        // R2: halving on mclk, every cycle pulse
        sysclk_en = 1; half_en = 1; mclk_pulse = 1;
        step(); check("R2 first half pulse suppressed", sysclk_pulse, 0);
        step(); check("R2 second half pulse passes", sysclk_pulse, 1);
        half_en = 0; mclk_pulse = 0; step();

        // R6/R7: long directed run with timeout divisor 256
        tick_div = 4; tmo_div = 256; tick_en = 1; tmo_en = 1; half_en = 1; mclk_pulse = 1;
        n_tick = 0; n_tmo = 0;
        repeat (2 * 4 * 256 + 8) step();
        check("R7 one timeout in directed run", n_tmo, 1);
        mclk_pulse = 0;

        // R8..R11 boundary cases
        set_rate(1, 0, 0, 0, 0, 128 * 48_000, 48_000);
        step(); check("R8 stereo low osr at limit", err_dac_ratio, 0);
        set_rate(1, 0, 0, 0, 0, 128 * 48_000 - 1, 48_000);
        step(); check("R8 stereo low osr below", err_dac_ratio, 1);
        set_rate(1, 0, 1, 0, 0, 64 * 48_000 - 1, 48_000);
        step(); check("R8 mono low osr below", err_dac_ratio, 1);
        set_rate(1, 0, 0, 1, 0, 256 * 44_100 - 1, 44_100);
        step(); check("R8 stereo high osr below", err_dac_ratio, 1);
        set_rate(0, 1, 0, 0, 1, 256 * 48_000 - 1, 48_000);
        step(); check("R9 adc high osr below", err_adc_ratio, 1);
        set_rate(0, 1, 0, 0, 0, 2_999_999, 8_000);
        step(); check("R10 below 3 MHz", err_abs_min, 1);
        set_rate(0, 0, 0, 1, 0, 5_999_999, 8_000);
        step(); check("R10 below 6 MHz at high osr", err_abs_min, 1);
        set_rate(1, 1, 0, 0, 0, 49_152_000, 88_200);
        step(); check("R11 both paths at 88.2 kHz", err_hirate, 1);
        set_rate(1, 1, 0, 0, 0, 49_152_000, 88_199);
        step(); check("R11 just below high rate", err_hirate, 0);

        // random phase
        for (int i = 0; i < 6000; i++) begin
            mclk_pulse = ($urandom % 4) != 0;
            fll_pulse  = ($urandom % 3) == 0;
            src_wr     = ($urandom % 40) == 0;
            src_wr_val = $urandom % 2;
            if ($urandom % 50 == 0) sysclk_en = ~sysclk_en;
            if ($urandom % 80 == 0) half_en = ~half_en;
            if ($urandom % 30 == 0) dsp_en = ~dsp_en;
            if ($urandom % 60 == 0) tick_en = ~tick_en;
            if ($urandom % 60 == 0) tmo_en = ~tmo_en;
            if ($urandom % 200 == 0) tick_div = DIV_W'($urandom % 6);
            if ($urandom % 200 == 0) tmo_div = TMO_W'($urandom % 5);
            if ($urandom % 10 == 0) begin
                {dac_l_on, dac_r_on, adc_l_on, adc_r_on} = 4'($urandom);
                {dac_mono, dac_hi_osr, adc_hi_osr} = 3'($urandom);
                fs_hz = ($urandom % 2) ? 48_000 : 96_000;
                sysclk_hz = fs_hz * (64 + $urandom % 256) - ($urandom % 2);
            end
            step();
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule